// File: doc/BRIEF.md
# Timer Tick Prescaler and Divider

This block turns one system clock into a tick enable for each of five timer channels. Two 8-bit prescalers each divide the system clock by their value plus one. The first prescaler serves the low channel group and the second serves the high group. Each channel then takes its group's prescaled rate through a power-of-two divider, or it takes an external tick strobe for that group. A 4-bit select code per channel picks which. The tick enables drive the counting logic of the channels, which lies outside this block.

Configuration enters through a single-cycle write port. The same port reads back combinationally. Two registers are visible. The prescaler register sits at offset 0x00, with the low-group prescaler in bits 7:0 and the high-group prescaler in bits 15:8. The select register sits at offset 0x04 and holds one 4-bit code per channel, with the code for channel n in bits 4n+3:4n. The external strobes are taken to be already synchronous to the system clock. All counters run freely, so a change of configuration never forces a restart.

Top module: `tick_gen_top`

## Requirements
- R1: While reset is high, and directly after it, every tick output is 0 and both registers read as 0.
- R2: A write to offset 0x00 stores data bits 15:0. A write to offset 0x04 stores data bits 19:0. Reads return the stored value with every other bit 0. A write to any other offset changes neither register, and a read of any other offset returns 0.
- R3: When a channel selects the divider with code c (0 to 3) and its group prescaler holds p, its tick repeats every (p+1)·2^(c+BASE) cycles. BASE is the divide base parameter and defaults to 1.
- R4: Channels 0 and 1 take their rate from the prescaler in bits 7:0. Channels 2, 3 and 4 take their rate from the prescaler in bits 15:8.
- R5: The code for channel n sits in select bits 4n+3:4n. Each channel follows only its own field.
- R6: A code whose bit is set in the external mask (default: only code 4) makes the channel's tick equal its group's external strobe, delayed by one cycle. Bit 0 of the strobe input serves channels 0 and 1. Bit 1 serves channels 2, 3 and 4.
- R7: A code of 4 or more that is not in the external mask gives the largest divide, the same as code 3.
- R8: With a total divide of 2 or more, every tick from the divider is high for exactly one cycle.
- R9: Writes to either register do not restart the prescaler or divider counters. A channel whose settings stay unchanged keeps its tick spacing across such writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration registers |
| addr | input | 8 | Byte offset for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| ext_tick | input | 2 | External tick strobes: bit 0 for the low group, bit 1 for the high group |
| tick_en | output | 5 | Per-channel tick enables, registered |

## Verification
The case that is hardest to reach from the ports is a configuration write that lands in the middle of a divide interval. Only a counter that restarts on a write would give itself away, and only as a stretched interval. The bench locks onto a tick of one channel and writes the other channel's field, or writes the same prescaler value again, in the cycle right after that tick. It then counts cycles to the next tick, which must match the undisturbed spacing. The sweeps give the two groups different prescaler values for every code, so a channel wired to the wrong group shows up as a wrong period.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int PRE_W     = 8;   // width of one prescaler
    localparam int SEL_W     = 4;   // width of one channel select code
    localparam int DIV_CODES = 4;   // codes 0..DIV_CODES-1 select distinct divides

    typedef enum logic [0:0] {
        GRP_LO = 1'b0,
        GRP_HI = 1'b1
    } grp_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre_hi;
        logic [PRE_W-1:0] pre_lo;
    } presc_cfg_t;

    typedef struct packed {
        logic       is_ext;
        logic [2:0] shift;
    } sel_dec_t;

    function automatic sel_dec_t decode_sel(input logic [SEL_W-1:0] code,
                                            input int base,
                                            input logic [15:0] ext_mask);
        sel_dec_t d;
        int c;
        d.is_ext = ext_mask[code];
        c = (int'(code) >= DIV_CODES) ? (DIV_CODES - 1) : int'(code);
        d.shift = 3'(c + base);
        return d;
    endfunction

    function automatic grp_e chan_group(input int ch, input int lo_count);
        return (ch < lo_count) ? GRP_LO : GRP_HI;
    endfunction

endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs
    import tick_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output presc_cfg_t              presc,
    output logic [NUM_CH*SEL_W-1:0] sel_flat
);
    localparam int SEL_BITS = NUM_CH * SEL_W;
    localparam int PRE_BITS = 2 * PRE_W;
    localparam logic [ADDR_W-1:0] OFS_PRE = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFS_SEL = ADDR_W'(8'h04);

    presc_cfg_t            presc_q;
    logic [SEL_BITS-1:0]   sel_q;
    logic                  unused_hi_bits;

    assign unused_hi_bits = ^wdata[DATA_W-1:SEL_BITS];

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
            sel_q   <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_PRE: presc_q <= presc_cfg_t'(wdata[PRE_BITS-1:0]);
                OFS_SEL: sel_q   <= wdata[SEL_BITS-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_PRE: rdata[PRE_BITS-1:0] = presc_q;
            OFS_SEL: rdata[SEL_BITS-1:0] = sel_q;
            default: rdata = '0;
        endcase
    end

    assign presc    = presc_q;
    assign sel_flat = sel_q;

    // R2: a write to the prescaler offset lands in the register
    p_pre_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_PRE) |=> presc_q == $past(wdata[PRE_BITS-1:0]));

    // R2: with no write strobe both registers hold their value
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(presc_q) && $stable(sel_q)));

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] pre,
    output logic             pulse
);
    logic [PRE_W-1:0] cnt_q;

    assign pulse = (cnt_q >= pre);

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (pulse) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    // R3: once inside the range, the count stays within the prescale value
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        ($stable(pre) && cnt_q <= pre) |=> (cnt_q <= pre || !$stable(pre)));

    // R3: each prescaled pulse restarts the interval
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        pulse |=> cnt_q == '0);

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int MAX_SHIFT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pulse_in,
    output logic [MAX_SHIFT:0] taps
);
    logic [MAX_SHIFT-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= '0;
        else if (pulse_in) cnt_q <= cnt_q + 1'b1;
    end

    assign taps[0] = pulse_in;

    for (genvar k = 1; k <= MAX_SHIFT; k++) begin : g_tap
        assign taps[k] = pulse_in & (&cnt_q[k-1:0]);
    end

    // R9: the divider count moves only on prescaled pulses, never on writes
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !pulse_in |=> $stable(cnt_q));

    // R3: each prescaled pulse advances the divider by one
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        pulse_in |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/tick_chan_sel.sv
module tick_chan_sel
    import tick_pkg::*;
#(
    parameter int          MAX_SHIFT = 4,
    parameter int          DIV_BASE  = 1,
    parameter logic [15:0] EXT_MASK  = 16'h0010
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   code,
    input  logic [MAX_SHIFT:0] taps,
    input  logic               ext_in,
    output logic               tick
);
    sel_dec_t dec;
    logic     div_hit;
    logic     tick_q;

    assign dec = decode_sel(code, DIV_BASE, EXT_MASK);

    always_comb begin
        div_hit = 1'b0;
        for (int k = 0; k <= MAX_SHIFT; k++) begin
            if (int'(dec.shift) == k) div_hit = taps[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= dec.is_ext ? ext_in : div_hit;
    end

    assign tick = tick_q;

    // R6: in external mode the tick is the strobe one cycle later
    p_ext_follow_r6: assert property (@(posedge clk) disable iff (rst)
        dec.is_ext |=> tick_q == $past(ext_in));

    // R4: with no prescaled pulse in the group there is no divided tick
    p_needs_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (!dec.is_ext && !taps[0]) |=> !tick_q);

    // R8: a divided tick with divide of two or more lasts one cycle
    p_one_wide_r8: assert property (@(posedge clk) disable iff (rst)
        (tick_q && !dec.is_ext && dec.shift != 3'd0 && $stable(code)) |=> !tick_q);

endmodule

// File: rtl/tick_gen_top.sv
module tick_gen_top
    import tick_pkg::*;
#(
    parameter int          NUM_CH   = 5,
    parameter int          LO_CH    = 2,
    parameter int          DIV_BASE = 1,
    parameter logic [15:0] EXT_MASK = 16'h0010,
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [1:0]        ext_tick,
    output logic [NUM_CH-1:0] tick_en
);
    localparam int MAX_SHIFT = DIV_BASE + DIV_CODES - 1;
    localparam int NUM_GRP   = 2;

    presc_cfg_t              presc;
    logic [NUM_CH*SEL_W-1:0] sel_flat;
    logic [PRE_W-1:0]        grp_pre   [NUM_GRP];
    logic [NUM_GRP-1:0]      grp_pulse;
    logic [MAX_SHIFT:0]      grp_taps  [NUM_GRP];

    tick_cfg_regs #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .presc    (presc),
        .sel_flat (sel_flat)
    );

    assign grp_pre[GRP_LO] = presc.pre_lo;
    assign grp_pre[GRP_HI] = presc.pre_hi;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        tick_prescaler u_pre (
            .clk   (clk),
            .rst   (rst),
            .pre   (grp_pre[g]),
            .pulse (grp_pulse[g])
        );

        tick_divider #(
            .MAX_SHIFT (MAX_SHIFT)
        ) u_div (
            .clk      (clk),
            .rst      (rst),
            .pulse_in (grp_pulse[g]),
            .taps     (grp_taps[g])
        );
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int G = int'(chan_group(ch, LO_CH));

        tick_chan_sel #(
            .MAX_SHIFT (MAX_SHIFT),
            .DIV_BASE  (DIV_BASE),
            .EXT_MASK  (EXT_MASK)
        ) u_sel (
            .clk    (clk),
            .rst    (rst),
            .code   (sel_flat[ch*SEL_W +: SEL_W]),
            .taps   (grp_taps[G]),
            .ext_in (ext_tick[G]),
            .tick   (tick_en[ch])
        );
    end

    // R1: no tick leaves the block in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> tick_en == '0);

endmodule

// File: tb/tick_gen_top_tb.sv
`timescale 1ns/1ps
module tick_gen_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  ext_tick = '0;
    logic [4:0]  tick_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    tick_gen_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .ext_tick (ext_tick),
        .tick_en  (tick_en)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        chk(rdata == exp, tag, rdata, exp);
        addr = '0;
    endtask

    function automatic logic [31:0] sel_word(input int c0, input int c1, input int c2,
                                             input int c3, input int c4);
        return {12'd0, 4'(c4), 4'(c3), 4'(c2), 4'(c1), 4'(c0)};
    endfunction

    task automatic rise(input int ch);
        while (tick_en[ch])  @(negedge clk);
        while (!tick_en[ch]) @(negedge clk);
    endtask

    task automatic measure(input int ch, output int width, output int period);
        rise(ch);
        rise(ch);
        width = 0; period = 0;
        while (tick_en[ch])  begin @(negedge clk); width++;  period++; end
        while (!tick_en[ch]) begin @(negedge clk); period++; end
    endtask

    function automatic int expect_period(input int pre, input int code);
        int c;
        c = (code > 3) ? 3 : code;
        return (pre + 1) << (c + 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int pres [4];
        int w, per, cnt;
        pres[0] = 0; pres[1] = 1; pres[2] = 2; pres[3] = 6;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(tick_en == 5'd0, "R1 ticks in reset", tick_en, 0);
        rd_chk(8'h00, 32'd0, "R1 prescaler reg in reset");
        rd_chk(8'h04, 32'd0, "R1 select reg in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(tick_en == 5'd0, "R1 ticks after reset", tick_en, 0);

        // R2: masking, readback and foreign offsets
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h0000_FFFF, "R2 prescaler readback");
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h04, 32'h000F_FFFF, "R2 select readback");
        wr(8'h08, 32'h1234_5678);
        rd_chk(8'h00, 32'h0000_FFFF, "R2 prescaler untouched by 0x08");
        rd_chk(8'h04, 32'h000F_FFFF, "R2 select untouched by 0x08");
        rd_chk(8'h08, 32'd0, "R2 unmapped read");

        // R3 R4 R8: sweep prescalers and codes, groups differ
        for (int pi = 0; pi < 4; pi++) begin
            int p_lo, p_hi;
            p_lo = pres[pi];
            p_hi = pres[(pi + 1) % 4];
            wr(8'h00, {16'd0, 8'(p_hi), 8'(p_lo)});
            for (int code = 0; code < 4; code++) begin
                wr(8'h04, sel_word(code, code, code, code, code));
                for (int ch = 0; ch < 5; ch++) begin
                    int p;
                    p = (ch < 2) ? p_lo : p_hi;
                    measure(ch, w, per);
                    chk(per == expect_period(p, code), $sformatf("R3 R4 period ch%0d code%0d", ch, code),
                        per, expect_period(p, code));
                    chk(w == 1, $sformatf("R8 width ch%0d", ch), w, 1);
                end
            end
        end

        // R3: largest prescaler
        wr(8'h00, {16'd0, 8'd0, 8'd255});
        wr(8'h04, sel_word(0, 0, 0, 0, 0));
        measure(0, w, per);
        chk(per == 512, "R3 prescaler 255", per, 512);

        // R5: each channel follows its own field
        wr(8'h00, {16'd0, 8'd1, 8'd1});
        wr(8'h04, sel_word(0, 1, 2, 3, 1));
        for (int ch = 0; ch < 5; ch++) begin
            int c;
            c = (ch == 4) ? 1 : ch;
            measure(ch, w, per);
            chk(per == expect_period(1, c), $sformatf("R5 field ch%0d", ch), per, expect_period(1, c));
        end

        // R7: non-external high codes clamp to the largest divide
        wr(8'h00, {16'd0, 8'd0, 8'd0});
        for (int code = 5; code < 16; code++) begin
            wr(8'h04, sel_word(0, 0, code, 0, 0));
            measure(2, w, per);
            chk(per == 16, $sformatf("R7 clamp code%0d", code), per, 16);
        end

        // R6: external strobes per group, one cycle later
        wr(8'h04, sel_word(4, 0, 0, 4, 0));
        @(negedge clk);
        ext_tick = 2'b01;
        @(negedge clk);
        ext_tick = 2'b00;
        chk(tick_en[0] == 1'b1, "R6 ch0 follows strobe 0", tick_en[0], 1);
        chk(tick_en[3] == 1'b0, "R6 ch3 ignores strobe 0", tick_en[3], 0);
        @(negedge clk);
        chk(tick_en[0] == 1'b0, "R6 ch0 drops", tick_en[0], 0);
        ext_tick = 2'b10;
        @(negedge clk);
        chk(tick_en[3] == 1'b1, "R6 ch3 follows strobe 1", tick_en[3], 1);
        chk(tick_en[0] == 1'b0, "R6 ch0 ignores strobe 1", tick_en[0], 0);
        cnt = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (tick_en[3]) cnt++;
        end
        ext_tick = 2'b00;
        chk(cnt == 3, "R6 held strobe passes through", cnt, 3);

        // R9: writes in mid interval do not restart counters
        wr(8'h00, {16'd0, 8'd0, 8'd1});
        wr(8'h04, sel_word(2, 0, 0, 0, 0));
        rise(0);
        rise(0);
        wr_en = 1'b1; addr = 8'h04; wdata = sel_word(2, 3, 0, 0, 0);
        @(negedge clk);
        wr_en = 1'b0; addr = '0;
        cnt = 1;
        while (!tick_en[0]) begin @(negedge clk); cnt++; end
        chk(cnt == 16, "R9 select write keeps ch0 spacing", cnt, 16);
        wr_en = 1'b1; addr = 8'h00; wdata = {16'd0, 8'd0, 8'd1};
        @(negedge clk);
        wr_en = 1'b0; addr = '0;
        cnt = 1;
        while (!tick_en[0]) begin @(negedge clk); cnt++; end
        chk(cnt == 16, "R9 prescaler rewrite keeps ch0 spacing", cnt, 16);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule